// File: doc/BRIEF.md
# Bus Transmit-Check Error Logger

This block watches a bus port while it drives the shared system bus. In every cycle it compares the value the port means to put on each line with the value it reads back from the bus. A mismatch is sorted by type into a sticky error register. It can raise a one-cycle fault strobe, a one-cycle data-error strobe, or both, and a read-side or write-side data error can request an interrupt.

The wide data field, its ECC field and the data-valid line are level-checked only in cycles where the port drives data (`drv_en_i`). The sequence field is level-checked only in cycles where the port raises send-data. The send-data, hold and data-error lines are checked only when the port itself raises them, and the only failure there is a line that was raised but reads back low.

The receive-side ECC results come in from outside. They decide whether a data mismatch is covered by an ECC error or must be promoted to a fatal fault, because without that promotion other nodes would take the bad data as good. Their syndromes are saved in a small set of slots, and a one-hot pointer marks the slot that holds the most severe saved error.

Top module: `txchk_logger`

## Requirements
- R1: In a cycle with `drv_en_i` high, a difference between the driven and observed data fields or between the driven and observed ECC fields sets error bit [0] (transmit check). With `drv_en_i` low, such a difference has no effect on any output.
- R2: A transmit-check mismatch with none of `ecc_unc_i`, `ecc_cwr_i`, `ecc_crd_i` high in the same cycle sets bit [1] (fatal transmit) and pulses `fault_o`. If any of those three is high, bit [1] stays clear and `fault_o` stays low.
- R3: The sequence field is compared only in cycles where `send_drv_i` is high. A mismatch there sets bit [2] (data/control transmit) and pulses `fault_o`. A sequence mismatch while `send_drv_i` is low has no effect.
- R4: If any of send-data, hold or data-error is driven high but observed low, bit [2] is set and `fault_o` pulses. A line that is driven low but observed high has no effect.
- R5: In a cycle with `drv_en_i` high, a data-valid mismatch sets bit [3]. It also sets bit [4] (read data error) when `cmd_wr_i` is low, or bit [5] (write data error) when `cmd_wr_i` is high.
- R6: `irq_o` is high exactly when `irq_en_i` is high and bit [4] or bit [5] is set. `irq_en_i` acts on `irq_o` in the same cycle.
- R7: Each cycle that contains a data error (a transmit-check mismatch, a data-valid mismatch, or any ECC flag) produces a one-cycle `derr_o` pulse one clock later, every time the error recurs. The ECC flags set bits [6] uncorrectable, [7] correctable-write and [8] correctable-read.
- R8: Each cycle that contains a fatal condition (bit [1] or bit [2] cause) produces a one-cycle `fault_o` pulse one clock later, every time the condition recurs.
- R9: Error bits are registered one clock after the compare and stay set until cleared. A cycle with `clr_we_i` high clears the bits that are set in `clr_mask_i`. A bit that is set and cleared in the same cycle stays set. The reset value is zero.
- R10: A cycle with an ECC flag stores `ecc_syn_i` into slot `ecc_slot_i` and marks the slot valid, unless the slot is already valid. A valid slot keeps its syndrome until its bit in `syn_clr_i` is pulsed, and that clear takes precedence over a store in the same cycle.
- R11: `slot_ptr_o` is one-hot or zero. The severity order is uncorrectable, then correctable-write, then correctable-read, lowest last. A store moves the pointer to its slot only when its severity is strictly higher than the severity already recorded. Clearing the slot the pointer names resets the pointer to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| drv_en_i | input | 1 | Port is driving data this cycle |
| data_drv_i | input | DATA_W | Data field as driven |
| data_obs_i | input | DATA_W | Data field as observed |
| ecc_drv_i | input | ECC_W | ECC field as driven |
| ecc_obs_i | input | ECC_W | ECC field as observed |
| seq_drv_i | input | SEQ_W | Sequence field as driven |
| seq_obs_i | input | SEQ_W | Sequence field as observed |
| send_drv_i | input | 1 | Port raises send-data |
| send_obs_i | input | 1 | Send-data as observed |
| hold_drv_i | input | 1 | Port raises hold |
| hold_obs_i | input | 1 | Hold as observed |
| derr_drv_i | input | 1 | Port raises data-error |
| derr_obs_i | input | 1 | Data-error as observed |
| dval_drv_i | input | 1 | Data-valid as driven |
| dval_obs_i | input | 1 | Data-valid as observed |
| cmd_wr_i | input | 1 | Current command is a write (0 = read) |
| ecc_unc_i | input | 1 | Receive-side uncorrectable ECC error |
| ecc_cwr_i | input | 1 | Receive-side correctable write ECC error |
| ecc_crd_i | input | 1 | Receive-side correctable read ECC error |
| ecc_slot_i | input | SLOT_IW | Syndrome slot for this ECC result |
| ecc_syn_i | input | SYN_W | Failing syndrome |
| irq_en_i | input | 1 | Interrupt enable |
| clr_we_i | input | 1 | Write-one-to-clear strobe for the error register |
| clr_mask_i | input | 9 | Bits to clear |
| syn_clr_i | input | SLOTS | Per-slot clear of the saved syndrome |
| fault_o | output | 1 | Fatal fault pulse |
| derr_o | output | 1 | Data-error re-assertion pulse |
| irq_o | output | 1 | Interrupt request (level 17) |
| err_o | output | 9 | Sticky error register |
| syn_vld_o | output | SLOTS | Slot valid flags |
| syn_data_o | output | SLOTS*SYN_W | Saved syndromes, slot k at [k*SYN_W +: SYN_W] |
| slot_ptr_o | output | SLOTS | One-hot pointer to the most severe saved slot |

## Verification
The assertions run on every cycle. They check that a data mismatch while driving sets the transmit bit, that an ECC-clean mismatch always becomes a fault, that a dropped hold line is caught, that ECC flags re-assert the data-error strobe, that bits stay sticky without a clear, that a valid syndrome slot holds its value, that the pointer stays one-hot or zero, and that a disabled interrupt stays low. Other behaviour can only be shown by the bench's scenarios: which checks are masked and when, the read/write split of the data-valid error, clear-versus-set precedence, and how the pointer ranks severities across successive stores. The bench does this with a behavioural reference model that is compared on every clock, plus directed checks.

// File: rtl/txchk_pkg.sv
// Shared constants for the transmit-check logger.
// Assumes a 9-bit error register with fixed bit positions known to software.
package txchk_pkg;
    localparam int ERR_W = 9;
    localparam int B_TCE = 0;  // data/ECC transmit mismatch
    localparam int B_FDT = 1;  // fatal: mismatch not covered by ECC
    localparam int B_DCT = 2;  // data/control line transmit mismatch
    localparam int B_DVT = 3;  // data-valid transmit mismatch
    localparam int B_RDE = 4;  // read data error
    localparam int B_WDE = 5;  // write data error
    localparam int B_UNC = 6;  // uncorrectable ECC
    localparam int B_CWR = 7;  // correctable write ECC
    localparam int B_CRD = 8;  // correctable read ECC

    // Severity used to rank saved syndromes; larger is more significant.
    typedef enum logic [1:0] {
        SEV_NONE = 2'd0,
        SEV_CRD  = 2'd1,
        SEV_CWR  = 2'd2,
        SEV_UNC  = 2'd3
    } sev_e;
endpackage

// File: rtl/txchk_cmp.sv
// Combinational comparator: turns driven/observed pairs into per-type hits.
// Assumes ECC result flags belong to the same transfer as the compared data.
module txchk_cmp
    import txchk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8,
    parameter int SEQ_W  = 4
) (
    input  logic              drv_en_i,
    input  logic [DATA_W-1:0] data_drv_i,
    input  logic [DATA_W-1:0] data_obs_i,
    input  logic [ECC_W-1:0]  ecc_drv_i,
    input  logic [ECC_W-1:0]  ecc_obs_i,
    input  logic [SEQ_W-1:0]  seq_drv_i,
    input  logic [SEQ_W-1:0]  seq_obs_i,
    input  logic              send_drv_i,
    input  logic              send_obs_i,
    input  logic              hold_drv_i,
    input  logic              hold_obs_i,
    input  logic              derr_drv_i,
    input  logic              derr_obs_i,
    input  logic              dval_drv_i,
    input  logic              dval_obs_i,
    input  logic              cmd_wr_i,
    input  logic              ecc_unc_i,
    input  logic              ecc_cwr_i,
    input  logic              ecc_crd_i,
    output logic [ERR_W-1:0]  hit_o,
    output logic              data_ev_o,
    output logic              fatal_ev_o,
    output sev_e              sev_o
);
    logic tce, dct, dvt, ecc_any, seq_bad, asserted_bad;

    // Level checks gated by driving; assertion checks gated by the port's own drive.
    always_comb begin
        ecc_any      = ecc_unc_i | ecc_cwr_i | ecc_crd_i;
        tce          = drv_en_i && ((data_drv_i != data_obs_i) || (ecc_drv_i != ecc_obs_i));
        seq_bad      = send_drv_i && (seq_drv_i != seq_obs_i);
        asserted_bad = (send_drv_i && !send_obs_i) || (hold_drv_i && !hold_obs_i)
                     || (derr_drv_i && !derr_obs_i);
        dct          = seq_bad || asserted_bad;
        dvt          = drv_en_i && (dval_drv_i != dval_obs_i);
    end

    // Assemble the hit vector and the event strobes.
    always_comb begin
        hit_o        = '0;
        hit_o[B_TCE] = tce;
        hit_o[B_FDT] = tce && !ecc_any;
        hit_o[B_DCT] = dct;
        hit_o[B_DVT] = dvt;
        hit_o[B_RDE] = dvt && !cmd_wr_i;
        hit_o[B_WDE] = dvt && cmd_wr_i;
        hit_o[B_UNC] = ecc_unc_i;
        hit_o[B_CWR] = ecc_cwr_i;
        hit_o[B_CRD] = ecc_crd_i;
        data_ev_o    = tce || dvt || ecc_any;
        fatal_ev_o   = (tce && !ecc_any) || dct;
    end

    // Rank the ECC result of this cycle.
    always_comb begin
        if (ecc_unc_i)      sev_o = SEV_UNC;
        else if (ecc_cwr_i) sev_o = SEV_CWR;
        else if (ecc_crd_i) sev_o = SEV_CRD;
        else                sev_o = SEV_NONE;
    end
endmodule

// File: rtl/txchk_accum.sv
// Sticky error register with write-one-to-clear, event pulses and interrupt.
// Assumes a set in the same cycle as a clear must win so no event is lost.
module txchk_accum
    import txchk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [ERR_W-1:0] hit_i,
    input  logic             data_ev_i,
    input  logic             fatal_ev_i,
    input  logic             clr_we_i,
    input  logic [ERR_W-1:0] clr_mask_i,
    input  logic             irq_en_i,
    output logic [ERR_W-1:0] err_o,
    output logic             fault_o,
    output logic             derr_o,
    output logic             irq_o
);
    logic [ERR_W-1:0] err_q;
    logic [ERR_W-1:0] clr_v;
    logic             fault_q, derr_q;

    // Select the bits a clear access removes this cycle.
    always_comb clr_v = clr_we_i ? clr_mask_i : '0;

    // Accumulate error types and register the one-cycle strobes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            err_q   <= '0;
            fault_q <= 1'b0;
            derr_q  <= 1'b0;
        end else begin
            err_q   <= (err_q & ~clr_v) | hit_i;
            fault_q <= fatal_ev_i;
            derr_q  <= data_ev_i;
        end
    end

    assign err_o   = err_q;
    assign fault_o = fault_q;
    assign derr_o  = derr_q;
    assign irq_o   = irq_en_i && (err_q[B_RDE] || err_q[B_WDE]);
endmodule

// File: rtl/txchk_synstore.sv
// Per-slot syndrome capture plus a one-hot pointer to the most severe slot.
// Assumes a valid slot is never overwritten; a slot clear beats a capture.
module txchk_synstore
    import txchk_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int SYN_W   = 8,
    parameter int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  sev_e                   sev_i,
    input  logic [SLOT_IW-1:0]     slot_i,
    input  logic [SYN_W-1:0]       syn_i,
    input  logic [SLOTS-1:0]       syn_clr_i,
    output logic [SLOTS-1:0]       vld_o,
    output logic [SLOTS*SYN_W-1:0] syn_o,
    output logic [SLOTS-1:0]       ptr_o
);
    logic             vld_q [SLOTS];
    logic [SYN_W-1:0] syn_q [SLOTS];
    logic [SLOTS-1:0] cap_v;
    logic [SLOTS-1:0] ptr_q, ptr_base;
    sev_e             sev_q, sev_base;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        // Capture enable for this slot: an ECC result aimed here at a free slot.
        assign cap_v[k] = (sev_i != SEV_NONE) && (slot_i == SLOT_IW'(k))
                        && !vld_q[k] && !syn_clr_i[k];

        // Hold or capture the syndrome of this slot.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                vld_q[k] <= 1'b0;
                syn_q[k] <= '0;
            end else if (syn_clr_i[k]) begin
                vld_q[k] <= 1'b0;
            end else if (cap_v[k]) begin
                vld_q[k] <= 1'b1;
                syn_q[k] <= syn_i;
            end
        end

        assign vld_o[k]                 = vld_q[k];
        assign syn_o[k*SYN_W +: SYN_W] = syn_q[k];
    end

    // Drop the pointer when its slot is being cleared.
    always_comb begin
        if (|(ptr_q & syn_clr_i)) begin
            ptr_base = '0;
            sev_base = SEV_NONE;
        end else begin
            ptr_base = ptr_q;
            sev_base = sev_q;
        end
    end

    // Move the pointer only to a strictly more severe capture.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_q <= '0;
            sev_q <= SEV_NONE;
        end else if ((|cap_v) && (sev_i > sev_base)) begin
            ptr_q <= cap_v;
            sev_q <= sev_i;
        end else begin
            ptr_q <= ptr_base;
            sev_q <= sev_base;
        end
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/txchk_logger.sv
// Top of the transmit-check logger: comparator, accumulator, syndrome store.
// Assumes all inputs are synchronous to clk_i and stable around its edge.
module txchk_logger
    import txchk_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int ECC_W   = 8,
    parameter int SEQ_W   = 4,
    parameter int SLOTS   = 4,
    parameter int SYN_W   = 8,
    parameter int SLOT_IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   drv_en_i,
    input  logic [DATA_W-1:0]      data_drv_i,
    input  logic [DATA_W-1:0]      data_obs_i,
    input  logic [ECC_W-1:0]       ecc_drv_i,
    input  logic [ECC_W-1:0]       ecc_obs_i,
    input  logic [SEQ_W-1:0]       seq_drv_i,
    input  logic [SEQ_W-1:0]       seq_obs_i,
    input  logic                   send_drv_i,
    input  logic                   send_obs_i,
    input  logic                   hold_drv_i,
    input  logic                   hold_obs_i,
    input  logic                   derr_drv_i,
    input  logic                   derr_obs_i,
    input  logic                   dval_drv_i,
    input  logic                   dval_obs_i,
    input  logic                   cmd_wr_i,
    input  logic                   ecc_unc_i,
    input  logic                   ecc_cwr_i,
    input  logic                   ecc_crd_i,
    input  logic [SLOT_IW-1:0]     ecc_slot_i,
    input  logic [SYN_W-1:0]       ecc_syn_i,
    input  logic                   irq_en_i,
    input  logic                   clr_we_i,
    input  logic [8:0]             clr_mask_i,
    input  logic [SLOTS-1:0]       syn_clr_i,
    output logic                   fault_o,
    output logic                   derr_o,
    output logic                   irq_o,
    output logic [8:0]             err_o,
    output logic [SLOTS-1:0]       syn_vld_o,
    output logic [SLOTS*SYN_W-1:0] syn_data_o,
    output logic [SLOTS-1:0]       slot_ptr_o
);
    logic [ERR_W-1:0] hit;
    logic             data_ev, fatal_ev;
    sev_e             sev;

    txchk_cmp #(.DATA_W(DATA_W), .ECC_W(ECC_W), .SEQ_W(SEQ_W)) u_cmp (
        .drv_en_i   (drv_en_i),
        .data_drv_i (data_drv_i), .data_obs_i (data_obs_i),
        .ecc_drv_i  (ecc_drv_i),  .ecc_obs_i  (ecc_obs_i),
        .seq_drv_i  (seq_drv_i),  .seq_obs_i  (seq_obs_i),
        .send_drv_i (send_drv_i), .send_obs_i (send_obs_i),
        .hold_drv_i (hold_drv_i), .hold_obs_i (hold_obs_i),
        .derr_drv_i (derr_drv_i), .derr_obs_i (derr_obs_i),
        .dval_drv_i (dval_drv_i), .dval_obs_i (dval_obs_i),
        .cmd_wr_i   (cmd_wr_i),
        .ecc_unc_i  (ecc_unc_i),  .ecc_cwr_i  (ecc_cwr_i), .ecc_crd_i (ecc_crd_i),
        .hit_o      (hit),
        .data_ev_o  (data_ev),
        .fatal_ev_o (fatal_ev),
        .sev_o      (sev)
    );

    txchk_accum u_accum (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hit_i      (hit),
        .data_ev_i  (data_ev),
        .fatal_ev_i (fatal_ev),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .irq_en_i   (irq_en_i),
        .err_o      (err_o),
        .fault_o    (fault_o),
        .derr_o     (derr_o),
        .irq_o      (irq_o)
    );

    txchk_synstore #(.SLOTS(SLOTS), .SYN_W(SYN_W), .SLOT_IW(SLOT_IW)) u_syn (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sev_i     (sev),
        .slot_i    (ecc_slot_i),
        .syn_i     (ecc_syn_i),
        .syn_clr_i (syn_clr_i),
        .vld_o     (syn_vld_o),
        .syn_o     (syn_data_o),
        .ptr_o     (slot_ptr_o)
    );
endmodule

// File: rtl/txchk_logger_chk.sv
// Property checker for txchk_logger, attached with bind below.
// Assumes port names identical to the top module.
module txchk_logger_chk #(
    parameter int DATA_W  = 64,
    parameter int ECC_W   = 8,
    parameter int SLOTS   = 4,
    parameter int SYN_W   = 8
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   drv_en_i,
    input logic [DATA_W-1:0]      data_drv_i,
    input logic [DATA_W-1:0]      data_obs_i,
    input logic                   hold_drv_i,
    input logic                   hold_obs_i,
    input logic                   ecc_unc_i,
    input logic                   ecc_cwr_i,
    input logic                   ecc_crd_i,
    input logic                   irq_en_i,
    input logic                   clr_we_i,
    input logic [8:0]             clr_mask_i,
    input logic [SLOTS-1:0]       syn_clr_i,
    input logic                   fault_o,
    input logic                   derr_o,
    input logic                   irq_o,
    input logic [8:0]             err_o,
    input logic [SLOTS-1:0]       syn_vld_o,
    input logic [SLOTS*SYN_W-1:0] syn_data_o,
    input logic [SLOTS-1:0]       slot_ptr_o
);
    // R1
    tce_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_en_i && (data_drv_i != data_obs_i)) |=> err_o[0]);

    // R2
    fatal_promote_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_en_i && (data_drv_i != data_obs_i) && !ecc_unc_i && !ecc_cwr_i && !ecc_crd_i)
        |=> (fault_o && err_o[1]));

    // R4
    hold_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_drv_i && !hold_obs_i) |=> (fault_o && err_o[2]));

    // R7
    ecc_derr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ecc_unc_i || ecc_cwr_i || ecc_crd_i) |=> derr_o);

    // R9
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o[0] && !(clr_we_i && clr_mask_i[0])) |=> err_o[0]);

    // R6
    irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |-> !irq_o);

    // R11
    ptr_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(slot_ptr_o));

    for (genvar k = 0; k < SLOTS; k++) begin : g_hold
        // R10
        syn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (syn_vld_o[k] && !syn_clr_i[k])
            |=> (syn_vld_o[k] && $stable(syn_data_o[k*SYN_W +: SYN_W])));
    end
endmodule

bind txchk_logger txchk_logger_chk #(
    .DATA_W(DATA_W), .ECC_W(ECC_W), .SLOTS(SLOTS), .SYN_W(SYN_W)
) i_chk (.*);

// File: tb/test_txchk_logger.sv
module test_txchk_logger;
    localparam int DATA_W = 64, ECC_W = 8, SEQ_W = 4, SLOTS = 4, SYN_W = 8, SLOT_IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic drv_en, send_d, send_o, hold_d, hold_o, derr_d, derr_oi, dval_d, dval_o, cmd_wr;
    logic [DATA_W-1:0] data_d, data_o;
    logic [ECC_W-1:0]  ecc_d, ecc_o;
    logic [SEQ_W-1:0]  seq_d, seq_o;
    logic unc, cwr, crd, irq_en, clr_we;
    logic [SLOT_IW-1:0] slot;
    logic [SYN_W-1:0]   syn;
    logic [8:0]         clr_mask;
    logic [SLOTS-1:0]   syn_clr;
    logic fault, derr, irq;
    logic [8:0] err;
    logic [SLOTS-1:0] vld, ptr;
    logic [SLOTS*SYN_W-1:0] synd;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10ns clk = ~clk;

    txchk_logger i_txchk_logger (
        .clk_i(clk), .rst_ni(rst_n), .drv_en_i(drv_en),
        .data_drv_i(data_d), .data_obs_i(data_o), .ecc_drv_i(ecc_d), .ecc_obs_i(ecc_o),
        .seq_drv_i(seq_d), .seq_obs_i(seq_o), .send_drv_i(send_d), .send_obs_i(send_o),
        .hold_drv_i(hold_d), .hold_obs_i(hold_o), .derr_drv_i(derr_d), .derr_obs_i(derr_oi),
        .dval_drv_i(dval_d), .dval_obs_i(dval_o), .cmd_wr_i(cmd_wr),
        .ecc_unc_i(unc), .ecc_cwr_i(cwr), .ecc_crd_i(crd), .ecc_slot_i(slot), .ecc_syn_i(syn),
        .irq_en_i(irq_en), .clr_we_i(clr_we), .clr_mask_i(clr_mask), .syn_clr_i(syn_clr),
        .fault_o(fault), .derr_o(derr), .irq_o(irq), .err_o(err),
        .syn_vld_o(vld), .syn_data_o(synd), .slot_ptr_o(ptr)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [8:0] m_err;
    bit m_fault, m_derr;
    bit m_vld [SLOTS];
    int m_syn [SLOTS];
    int m_ptr, m_sev;

    always @(posedge clk) begin
        bit anyecc, tce, dct, dvt, got;
        int sev;
        if (!rst_n) begin
            m_err = 0; m_fault = 0; m_derr = 0; m_ptr = 0; m_sev = 0;
            for (int k = 0; k < SLOTS; k++) begin m_vld[k] = 0; m_syn[k] = 0; end
        end else begin
            anyecc = unc || cwr || crd;
            tce = drv_en && (data_d != data_o || ecc_d != ecc_o);
            dct = (send_d && seq_d != seq_o) || (send_d && !send_o)
               || (hold_d && !hold_o) || (derr_d && !derr_oi);
            dvt = drv_en && (dval_d != dval_o);
            m_fault = (tce && !anyecc) || dct;
            m_derr  = tce || dvt || anyecc;
            if (clr_we) m_err = m_err & ~clr_mask;
            m_err = m_err | {crd, cwr, unc, dvt && cmd_wr, dvt && !cmd_wr, dvt, dct,
                             tce && !anyecc, tce};
            sev = unc ? 3 : cwr ? 2 : crd ? 1 : 0;
            if ((m_ptr & int'(syn_clr)) != 0) begin m_ptr = 0; m_sev = 0; end
            got = 0;
            for (int k = 0; k < SLOTS; k++) begin
                if (syn_clr[k]) m_vld[k] = 0;
                else if (sev > 0 && int'(slot) == k && !m_vld[k]) begin
                    m_vld[k] = 1; m_syn[k] = int'(syn); got = 1;
                end
            end
            if (got && sev > m_sev) begin m_ptr = 1 << slot; m_sev = sev; end
        end
    end

    // Compare the model with the outputs on every clock, between edges.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 model fault", 64'(fault), 64'(m_fault));
            chk("R7 model derr", 64'(derr), 64'(m_derr));
            chk("R9 model err", 64'(err), 64'(m_err));
            chk("R6 model irq", 64'(irq), 64'(irq_en && (m_err[4] || m_err[5])));
            chk("R11 model ptr", 64'(ptr), 64'(m_ptr));
            for (int k = 0; k < SLOTS; k++) begin
                chk("R10 model vld", 64'(vld[k]), 64'(m_vld[k]));
                if (m_vld[k]) chk("R10 model syn", 64'(synd[k*SYN_W +: SYN_W]), 64'(m_syn[k]));
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic idle();
        drv_en = 0; data_d = 64'h1234; data_o = 64'h1234; ecc_d = 8'h5a; ecc_o = 8'h5a;
        seq_d = 4'h3; seq_o = 4'h3; send_d = 0; send_o = 0; hold_d = 0; hold_o = 0;
        derr_d = 0; derr_oi = 0; dval_d = 0; dval_o = 0; cmd_wr = 0;
        unc = 0; cwr = 0; crd = 0; slot = 0; syn = 0; clr_we = 0; clr_mask = 0; syn_clr = 0;
    endtask

    task automatic tick();
        @(posedge clk); #5ns;
    endtask

    task automatic clear_all();
        idle(); clr_we = 1; clr_mask = 9'h1ff; tick(); idle();
    endtask

    initial begin
        idle(); irq_en = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R9 reset err", 64'(err), 0);
        chk("R8 reset fault", 64'(fault), 0);
        chk("R11 reset ptr", 64'(ptr), 0);

        // R1: mismatch while not driving is ignored
        data_o = 64'hdead; tick();
        chk("R1 masked", 64'(err), 0); chk("R1 masked fault", 64'(fault), 0); idle();

        // R1/R2: clean mismatch while driving is fatal
        drv_en = 1; data_o = 64'hbeef; tick();
        chk("R1 tce", 64'(err[0]), 1); chk("R2 fdtce", 64'(err[1]), 1);
        chk("R2 fault", 64'(fault), 1); chk("R7 derr", 64'(derr), 1);
        idle(); tick();
        chk("R8 pulse ends", 64'(fault), 0);
        drv_en = 1; ecc_o = 8'h00; tick();
        chk("R8 fault again", 64'(fault), 1); idle();
        clear_all();
        chk("R9 cleared", 64'(err), 0);

        // R2: mismatch covered by ECC; R10/R11 capture
        drv_en = 1; data_o = 64'h0; crd = 1; slot = 2; syn = 8'h15; tick();
        chk("R2 tce covered", 64'(err[0]), 1); chk("R2 no fdtce", 64'(err[1]), 0);
        chk("R2 no fault", 64'(fault), 0); chk("R7 crd bit", 64'(err[8]), 1);
        chk("R10 vld", 64'(vld), 4'b0100); chk("R10 syn2", 64'(synd[2*SYN_W +: SYN_W]), 8'h15);
        chk("R11 ptr crd", 64'(ptr), 4'b0100); idle();
        unc = 1; slot = 0; syn = 8'h2a; tick();
        chk("R11 ptr unc", 64'(ptr), 4'b0001); chk("R7 unc derr", 64'(derr), 1); idle();
        tick(); chk("R7 derr ends", 64'(derr), 0);
        crd = 1; slot = 1; syn = 8'h33; tick();
        chk("R11 ptr kept", 64'(ptr), 4'b0001); chk("R10 vld3", 64'(vld), 4'b0111); idle();
        cwr = 1; slot = 0; syn = 8'h44; tick();
        chk("R10 held", 64'(synd[0 +: SYN_W]), 8'h2a); chk("R7 derr repeat", 64'(derr), 1);
        idle(); syn_clr = 4'b0001; tick();
        chk("R10 slot clr", 64'(vld), 4'b0110); chk("R11 ptr drop", 64'(ptr), 0); idle();

        // R3: sequence field checked only with send-data raised
        clear_all();
        send_d = 1; send_o = 1; seq_o = 4'h9; tick();
        chk("R3 dctce", 64'(err[2]), 1); chk("R3 fault", 64'(fault), 1); idle();
        clear_all();
        seq_o = 4'h9; tick();
        chk("R3 masked", 64'(err), 0); chk("R3 masked fault", 64'(fault), 0); idle();

        // R4: only lines the port raises are checked
        hold_o = 1; derr_oi = 1; send_o = 1; tick();
        chk("R4 low ignored", 64'(err), 0); chk("R4 no fault", 64'(fault), 0); idle();
        hold_d = 1; tick();
        chk("R4 hold", 64'(err[2]), 1); chk("R4 hold fault", 64'(fault), 1); idle();
        clear_all();
        derr_d = 1; tick();
        chk("R4 derr line", 64'(err[2]), 1); idle();

        // R5/R6: data-valid split by command, interrupt gating
        clear_all(); irq_en = 1;
        drv_en = 1; dval_d = 1; cmd_wr = 0; tick();
        chk("R5 dvtce", 64'(err[3]), 1); chk("R5 rde", 64'(err[4]), 1);
        chk("R5 no wde", 64'(err[5]), 0); chk("R6 irq", 64'(irq), 1); idle();
        drv_en = 1; dval_o = 1; cmd_wr = 1; tick();
        chk("R5 wde", 64'(err[5]), 1); idle();
        irq_en = 0; #1ns; chk("R6 irq off", 64'(irq), 0);

        // R9: set beats clear in the same cycle
        clr_we = 1; clr_mask = 9'h1ff; drv_en = 1; data_o = 64'h77; tick();
        chk("R9 set wins", 64'(err[0]), 1); chk("R9 wde cleared", 64'(err[5]), 0); idle();
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule